// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins. Each pin passes through a two-flop synchronizer. A per-pin sense code then selects an edge or level condition, and a matching event sets that pin's pending bit. Pending bits stay set until software clears them. Each pin has a mask bit and a 4-bit priority field. A pin whose priority field is zero stays silent even when it is unmasked. The block drives one interrupt output per pin and one combined output.

Software reaches the block through a flat register port: a 3-bit word address, a write enable, write data and combinational read data. The port has six registers: sense, priority, pending, mask-set, mask-clear and a mode register. All per-pin fields are packed from the most significant end, so pin 0 always sits in the top bits of its register. When the mode register's individual-interrupt bit is clear, the per-pin outputs are held low and only the combined output reports activity.

Top module: `ext_irq_pins`

## Requirements
- R1: After reset, every pin is masked and all of the following read as 0: priority fields, sense fields, pending bits and the mode bit. Both irqOut and irqAny are low. The synchronizer stages also reset to 0.
- R2: Address 0 holds the sense fields, SENSE_W bits per pin (4 by default, 2 optional). Pin k's field starts at bit 32-(k+1)*SENSE_W. Bits below the implemented fields read as 0.
- R3: Sense code 0 detects falling edges, code 1 rising edges and code 4 both edges. Code 4 needs 4-bit fields. A pin change applied before a rising clock edge shows as pending after the third rising edge.
- R4: Sense code 2 detects a low level and code 3 a high level. While the synchronized pin stays at its active level, the pending bit sets again on every cycle, even right after software clears it.
- R5: Sense codes 5 to 15 never set a pending bit.
- R6: Address 2 holds the pending bits, with pin k at bit PEND_W-1-k (PEND_W = 8 by default). A write clears each bit written as 0 and keeps each bit written as 1. An event in the same cycle as the write wins over the clear.
- R7: A write to address 3 masks each pin whose bit (PEND_W-1-k) is 1. Pins whose bit is 0 are unaffected. Address 3 reads as 0.
- R8: A write to address 4 unmasks each pin whose bit (PEND_W-1-k) is 1. Pins whose bit is 0 are unaffected. Address 4 reads as 0.
- R9: Address 1 holds a 4-bit priority field per pin, with pin k's field at bit 32-(k+1)*4. A field of zero blocks that pin's interrupt.
- R10: irqOut[k] is high when pin k is pending, unmasked, has a nonzero priority and the mode bit is set. irqAny is the OR over all pins of (pending, unmasked, nonzero priority), whatever the mode bit holds.
- R11: Address 5 stores only bit 23, the individual-interrupt-mode bit. Every other bit reads as 0.
- R12: Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw external interrupt pins, bit k is pin k |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqOut | output | NUM_PINS | Per-pin interrupt, bit k is pin k |
| irqAny | output | 1 | Combined interrupt |

## Verification
The assertions assume that a register write takes effect at the clock edge where busWrEn is high. They also assume that the address and data are known, stable values across that edge. The pins are treated as fully asynchronous, so the assertions place no condition on them. The bench changes every input, pins included, only at the falling clock edge, so all inputs are defined and stable at each rising edge. Its random phase mixes pin toggles with writes of arbitrary data to all eight addresses, invalid sense codes included.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_SENSE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRIO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MSET  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MCLR  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd5;
  localparam int MODE_BIT = 23;
  localparam int PRIO_W   = 4;

  typedef enum logic [3:0] {
    SENSE_FALL = 4'd0,
    SENSE_RISE = 4'd1,
    SENSE_LOW  = 4'd2,
    SENSE_HIGH = 4'd3,
    SENSE_BOTH = 4'd4
  } senseCode_e;

  typedef struct packed {
    logic senseWr;
    logic prioWr;
    logic pendWr;
    logic maskSetWr;
    logic maskClrWr;
    logic modeWr;
  } regStrobes_t;
endpackage

// File: rtl/irqpin_ctrl.sv
module irqpin_ctrl
  import extirq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      case (addr)
        ADDR_SENSE: strobes.senseWr   = 1'b1;
        ADDR_PRIO:  strobes.prioWr    = 1'b1;
        ADDR_PEND:  strobes.pendWr    = 1'b1;
        ADDR_MSET:  strobes.maskSetWr = 1'b1;
        ADDR_MCLR:  strobes.maskClrWr = 1'b1;
        ADDR_MODE:  strobes.modeWr    = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqpin_sense.sv
module irqpin_sense
  import extirq_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinRaw,
  input  logic [SENSE_W-1:0] code,
  output logic               evt
);
  logic syncA, syncB, lastB;
  logic [3:0] codeWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      lastB <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  assign codeWide = 4'(code);

  always_comb begin
    case (codeWide)
      SENSE_FALL: evt = lastB & ~syncB;
      SENSE_RISE: evt = ~lastB & syncB;
      SENSE_LOW:  evt = ~syncB;
      SENSE_HIGH: evt = syncB;
      SENSE_BOTH: evt = lastB ^ syncB;
      default:    evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/irqpin_dp.sv
module irqpin_dp
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PEND_W   = 8,
  parameter bit HAS_MODE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [31:0]         rdData,
  output logic [NUM_PINS-1:0] irqOut,
  output logic                irqAny
);
  localparam int SENSE_USED = NUM_PINS * SENSE_W;
  localparam int PRIO_USED  = NUM_PINS * PRIO_W;
  localparam logic [31:0] SENSE_KEEP = 32'hFFFF_FFFF << (32 - SENSE_USED);
  localparam logic [31:0] PRIO_KEEP  = 32'hFFFF_FFFF << (32 - PRIO_USED);
  localparam logic [31:0] MODE_MASK  = 32'd1 << MODE_BIT;

  logic [31:0]         senseReg, prioReg;
  logic [NUM_PINS-1:0] pendReg, maskReg, evtVec, gated;
  logic [PEND_W-1:0]   pendView;
  logic                modeBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseReg <= '0;
      prioReg  <= '0;
    end else begin
      if (strobes.senseWr) senseReg <= wrData & SENSE_KEEP;
      if (strobes.prioWr)  prioReg  <= wrData & PRIO_KEEP;
    end
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    localparam int SEL = PEND_W - 1 - k;
    logic keepBit, setBit, clrBit, prioOn;

    irqpin_sense #(.SENSE_W(SENSE_W)) u_sense (
      .clk    (clk),
      .rstN   (rstN),
      .pinRaw (pinIn[k]),
      .code   (senseReg[32-(k+1)*SENSE_W +: SENSE_W]),
      .evt    (evtVec[k])
    );

    assign keepBit = ~strobes.pendWr | wrData[SEL];
    assign setBit  = strobes.maskSetWr & wrData[SEL];
    assign clrBit  = strobes.maskClrWr & wrData[SEL];
    assign prioOn  = |prioReg[32-(k+1)*PRIO_W +: PRIO_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendReg[k] <= 1'b0;
        maskReg[k] <= 1'b1;
      end else begin
        pendReg[k] <= (pendReg[k] & keepBit) | evtVec[k];
        if (setBit)      maskReg[k] <= 1'b1;
        else if (clrBit) maskReg[k] <= 1'b0;
      end
    end

    assign gated[k]  = pendReg[k] & ~maskReg[k] & prioOn;
    assign irqOut[k] = gated[k] & modeBit;
  end

  if (HAS_MODE) begin : g_mode
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              modeBit <= 1'b0;
      else if (strobes.modeWr) modeBit <= wrData[MODE_BIT];
    end
  end else begin : g_nomode
    assign modeBit = 1'b1;
  end

  assign irqAny = |gated;

  always_comb begin
    pendView = '0;
    for (int k = 0; k < NUM_PINS; k++) pendView[PEND_W-1-k] = pendReg[k];
  end

  always_comb begin
    case (addr)
      ADDR_SENSE: rdData = senseReg;
      ADDR_PRIO:  rdData = prioReg;
      ADDR_PEND:  rdData = 32'(pendView);
      ADDR_MODE:  rdData = (HAS_MODE && modeBit) ? MODE_MASK : 32'd0;
      default:    rdData = 32'd0;
    endcase
  end
endmodule

// File: rtl/ext_irq_pins.sv
module ext_irq_pins
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PEND_W   = 8,
  parameter bit HAS_MODE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [2:0]          busAddr,
  input  logic                busWrEn,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  output logic [NUM_PINS-1:0] irqOut,
  output logic                irqAny
);
  regStrobes_t strobes;

  irqpin_ctrl u_ctrl (
    .wrEn    (busWrEn),
    .addr    (busAddr),
    .strobes (strobes)
  );

  irqpin_dp #(
    .NUM_PINS (NUM_PINS),
    .SENSE_W  (SENSE_W),
    .PEND_W   (PEND_W),
    .HAS_MODE (HAS_MODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (busAddr),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .irqAny  (irqAny)
  );
endmodule

// File: rtl/irqpin_chk.sv
module irqpin_chk
  import extirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int PEND_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          busAddr,
  input logic                busWrEn,
  input logic [31:0]         busWrData,
  input logic [NUM_PINS-1:0] irqOut,
  input logic                irqAny
);
  // R10
  any_covers_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> irqAny);

  // R7
  mask_all_silences_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MSET && (&busWrData[PEND_W-1 -: NUM_PINS]))
    |=> (irqOut == '0 && !irqAny));

  // R9
  prio_zero_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_PRIO && busWrData == 32'd0) |=> !irqAny);

  // R10
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MODE && !busWrData[MODE_BIT]) |=> (irqOut == '0));
endmodule

bind ext_irq_pins irqpin_chk #(.NUM_PINS(NUM_PINS), .PEND_W(PEND_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .irqOut    (irqOut),
  .irqAny    (irqAny)
);

// File: tb/ext_irq_pins_tb.sv
module ext_irq_pins_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  irqOut;
  logic        irqAny;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0]  mS1 = '0, mS2 = '0, mPrev = '0, mPend = '0, mMask = 8'hFF;
  logic [31:0] mSense = '0, mPrio = '0;
  logic        mMode = 1'b0;

  ext_irq_pins u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .irqAny    (irqAny)
  );

  always #4 clk = ~clk;

  function automatic logic senseHit(logic [3:0] code, logic cur, logic prv);
    case (code)
      4'd0: return prv & ~cur;
      4'd1: return ~prv & cur;
      4'd2: return ~cur;
      4'd3: return cur;
      4'd4: return prv ^ cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] expGated();
    logic [7:0] g;
    for (int k = 0; k < 8; k++)
      g[k] = mPend[k] & ~mMask[k] & (mPrio[31-4*k -: 4] != 4'd0);
    return g;
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] a);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[7-k] = mPend[k];
    case (a)
      3'd0: return mSense;
      3'd1: return mPrio;
      3'd2: return {24'd0, v};
      3'd5: return mMode ? 32'h0080_0000 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string readTag(logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R9";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic modelStep();
    logic [7:0] nPend;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mPend = '0; mMask = 8'hFF;
      mSense = '0; mPrio = '0; mMode = 1'b0;
    end else begin
      nPend = mPend;
      for (int k = 0; k < 8; k++) begin
        if (busWrEn && busAddr == 3'd2) nPend[k] = mPend[k] & busWrData[7-k];
        nPend[k] = nPend[k] | senseHit(mSense[31-4*k -: 4], mS2[k], mPrev[k]);
      end
      mPend = nPend;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
      if (busWrEn) begin
        case (busAddr)
          3'd0: mSense = busWrData;
          3'd1: mPrio = busWrData;
          3'd3: for (int k = 0; k < 8; k++) if (busWrData[7-k]) mMask[k] = 1'b1;
          3'd4: for (int k = 0; k < 8; k++) if (busWrData[7-k]) mMask[k] = 1'b0;
          3'd5: mMode = busWrData[23];
          default: ;
        endcase
      end
    end
  endtask

  task automatic cycle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    cycle();
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag, logic [31:0] exp);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic chkOut(string tag, logic [7:0] expIrq, logic expAny);
    #1;
    chk(tag, {24'd0, irqOut}, {24'd0, expIrq});
    chk(tag, {31'd0, irqAny}, {31'd0, expAny});
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    cycle(3);
    rstN = 1'b1;
    cycle();
    // R1 reset state
    rd(3'd0, "R1", 32'd0);
    rd(3'd1, "R1", 32'd0);
    rd(3'd2, "R1", 32'd0);
    rd(3'd5, "R1", 32'd0);
    chkOut("R1", 8'h00, 1'b0);

    // R2 sense readback: pin0 rise, pin1 both, pin2 low, pin3 high, pin4 code 5, pin5 fall
    wr(3'd0, 32'h1423_5000);
    rd(3'd0, "R2", 32'h1423_5000);
    // R9 priority storage, pins 6 and 7 left at zero
    wr(3'd1, 32'hFFFF_FF00);
    rd(3'd1, "R9", 32'hFFFF_FF00);
    wr(3'd5, 32'h0080_0000);
    wr(3'd4, 32'h0000_00FF);
    // R10 low-level pin2 pending and unmasked
    chkOut("R10", 8'h04, 1'b1);

    // R4 level re-asserts after clear
    wr(3'd2, 32'd0);
    rd(3'd2, "R4", 32'h20);
    pinIn[2] = 1'b1;
    cycle(4);
    wr(3'd2, 32'd0);
    rd(3'd2, "R4", 32'h00);
    chkOut("R4", 8'h00, 1'b0);

    // R3 rising edge latency of three edges
    pinIn[0] = 1'b1;
    cycle(2);
    rd(3'd2, "R3", 32'h00);
    cycle();
    rd(3'd2, "R3", 32'h80);
    chkOut("R10", 8'h01, 1'b1);

    // R7 mask set
    wr(3'd3, 32'h80);
    chkOut("R7", 8'h00, 1'b0);
    rd(3'd3, "R7", 32'd0);
    rd(3'd2, "R7", 32'h80);
    pinIn[1] = 1'b1;
    cycle(3);
    chkOut("R3", 8'h02, 1'b1);
    wr(3'd3, 32'h00);
    chkOut("R7", 8'h02, 1'b1);

    // R8 mask clear
    wr(3'd4, 32'h80);
    chkOut("R8", 8'h03, 1'b1);
    wr(3'd4, 32'h00);
    chkOut("R8", 8'h03, 1'b1);
    rd(3'd4, "R8", 32'd0);

    // R9 zero priority blocks
    wr(3'd1, 32'h0FFF_FF00);
    chkOut("R9", 8'h02, 1'b1);
    wr(3'd1, 32'h00FF_FF00);
    chkOut("R9", 8'h00, 1'b0);
    rd(3'd2, "R9", 32'hC0);
    wr(3'd1, 32'hFFFF_FF00);

    // R10 / R11 mode bit
    wr(3'd5, 32'd0);
    chkOut("R10", 8'h00, 1'b1);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, "R11", 32'h0080_0000);
    chkOut("R11", 8'h03, 1'b1);

    // R6 write-0-to-clear, write-1-keeps
    wr(3'd2, 32'h80);
    rd(3'd2, "R6", 32'h80);
    wr(3'd2, 32'h7F);
    rd(3'd2, "R6", 32'h00);
    // R6 event in the clearing cycle wins (pin1 falling, both-edge code)
    pinIn[1] = 1'b0;
    cycle(2);
    wr(3'd2, 32'd0);
    rd(3'd2, "R6", 32'h40);
    wr(3'd2, 32'd0);
    rd(3'd2, "R6", 32'h00);

    // R5 invalid code on pin4
    pinIn[4] = 1'b1; cycle(3);
    pinIn[4] = 1'b0; cycle(3);
    rd(3'd2, "R5", 32'h00);
    chkOut("R5", 8'h00, 1'b0);

    // R3 falling-only on pin5
    pinIn[5] = 1'b1; cycle(4);
    rd(3'd2, "R3", 32'h00);
    pinIn[5] = 1'b0; cycle(3);
    rd(3'd2, "R3", 32'h04);

    // R12 unmapped addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, "R12", 32'd0);
    rd(3'd7, "R12", 32'd0);
    rd(3'd0, "R12", 32'h1423_5000);
    rd(3'd2, "R12", 32'h04);

    // random phase against the model
    for (int it = 0; it < 4000; it++) begin
      for (int k = 0; k < 8; k++) if (($urandom % 4) == 0) pinIn[k] = ~pinIn[k];
      busAddr = 3'($urandom % 8);
      busWrEn = (($urandom % 6) == 0);
      busWrData = $urandom;
      if (busAddr == 3'd2 && ($urandom % 2) == 0) busWrData = 32'd0;
      #1;
      if (!busWrEn) chk(readTag(busAddr), busRdData, expRead(busAddr));
      chk("R10", {24'd0, irqOut}, {24'd0, expGated() & {8{mMode}}});
      chk("R10", {31'd0, irqAny}, {31'd0, |expGated()});
      cycle();
    end
    busWrEn = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule